// File: doc/BRIEF.md
# UART Transmit Framer with Fractional Baud Divisor

This block turns bytes into asynchronous serial characters on a single TX line. Three write-only configuration words set the character format and the bit timing. The format word selects 5 to 8 data bits, one or two stop bits, and no, odd or even parity. The timing words are an integer divisor and a 3-bit fractional value. Bytes arrive one at a time over a valid/ready handshake. Two status flags show whether the byte slot is free and whether the line has gone quiet.

A character starts one clock after a byte is accepted, provided the integer divisor is non-zero. The block copies the format and the bit period at that moment and keeps them for the whole character. A configuration write made during a character therefore applies only to the next one. While the integer divisor is zero, an accepted byte waits in the slot and the line stays high.

Top module: `uart_tx_framer`

## Requirements
- R1: After synchronous reset, txd is 1, buf_empty, xmit_empty and tx_ready are 1, and the format, divisor and fraction registers hold 0.
- R2: The number of data bits is format bits [1:0] plus 5. The data bits are sent LSB first, and byte bits above that count are not sent.
- R3: Format bit 2 set gives two stop bits; clear gives one stop bit.
- R4: Format bit 5 set adds a parity bit after the data. Format bit 3 then picks even parity (set) or odd parity (clear), computed over the transmitted data bits only.
- R5: Every bit lasts ((16 × divisor) mod 65536) + (fraction mod 8) + 16 clock cycles.
- R6: While the divisor register is 0, no character starts: an accepted byte waits, txd stays 1 and both flags stay 0. The character begins one cycle after a non-zero divisor is written.
- R7: A byte is accepted when tx_valid and tx_ready are both 1, and tx_ready equals buf_empty. Acceptance clears buf_empty and xmit_empty on the next cycle. Both flags return to 1 in the cycle after the last stop bit ends, and no second byte is taken before then.
- R8: A character is a low start bit, then the data bits, then the optional parity bit, then high stop bits. The line is high whenever no character is being sent, and the start bit begins on the clock edge after acceptance.
- R9: The format and bit period are captured when a character starts. Writes made during a character do not change it and apply to the next character.
- R10: cfg_sel selects the target of a write: 0 writes the format (cfg_wdata bits 5, 3, 2, 1:0), 1 writes the divisor (all cfg_wdata bits), 2 writes the fraction (cfg_wdata bits 2:0), and 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_wdata | input | DIV_W | Configuration write data |
| tx_valid | input | 1 | A byte is offered |
| tx_data | input | 8 | Offered byte |
| tx_ready | output | 1 | The byte slot is free |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | No byte is waiting or being sent |
| xmit_empty | output | 1 | The line has finished the last character |

## Verification
The bench targets several corner cases and the fault each one would reveal:
- Divisor wrap: the integer divisor is set so that 16 × divisor overflows 16 bits. A design that kept the carry would stretch every bit by 65536 clocks and never finish the character.
- Odd and even parity: bytes with an odd number of ones are sent under both parity modes. A 7-bit character is sent whose byte has its top bit set, which catches a parity computed over bits that are not sent.
- Zero divisor: a byte is offered while the divisor is zero. A design that started the character anyway would drive the line low early.
- Mid-character writes: the divisor and format are rewritten during a start bit. A design without the snapshot would change the bit timing and data length partway through the character.
- Ignored select: writes on select code 3 precede every character. Any leak of those writes into a live register would change the bit timing or the format.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;
  localparam int DATA_W = 8;
  // data bits + parity + two stop bits
  localparam int BODY_W = DATA_W + 3;
  localparam int CNT_W  = 4;

  typedef struct packed {
    logic       par_en;
    logic       par_even;
    logic       two_stop;
    logic [1:0] len_code;
  } line_fmt_t;

  typedef enum logic [1:0] {
    SEL_FMT  = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_FRAC = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/uart_tx_cfg.sv
`timescale 1ns/1ps
module uart_tx_cfg
  import uart_tx_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int SCALED_W = 16,
  parameter int FRAC_W   = 3,
  localparam int PER_W   = SCALED_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [DIV_W-1:0] wdata,
  output line_fmt_t        fmt,
  output logic [PER_W-1:0] period,
  output logic             div_nz
);
  line_fmt_t           fmt_q;
  logic [DIV_W-1:0]    div_q;
  logic [FRAC_W-1:0]   frac_q;
  logic [SCALED_W-1:0] scaled;

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q  <= '0;
      div_q  <= '0;
      frac_q <= '0;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_FMT:  fmt_q  <= '{par_en: wdata[5], par_even: wdata[3],
                              two_stop: wdata[2], len_code: wdata[1:0]};
        SEL_DIV:  div_q  <= wdata;
        SEL_FRAC: frac_q <= wdata[FRAC_W-1:0];
        default:  ;
      endcase
    end
  end

  // scaled integer term keeps only its low SCALED_W bits
  assign scaled = SCALED_W'({div_q, 4'b0000});
  assign period = {1'b0, scaled} + PER_W'(frac_q) + PER_W'(16);
  assign div_nz = |div_q;
  assign fmt    = fmt_q;

  // R10: code 3 writes must not disturb any register
  p_sel_none_inert_r10: assert property (@(posedge clk) disable iff (rst)
    (we && sel == 2'd3) |=> ($stable(div_q) && $stable(frac_q) && $stable(fmt_q)));
endmodule

// File: rtl/uart_tx_baud.sv
`timescale 1ns/1ps
module uart_tx_baud #(
  parameter int PER_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt;

  assign tick = run && (cnt == period - PER_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + PER_W'(1);
  end

  p_cnt_in_period_r5: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < period));
endmodule

// File: rtl/uart_tx_shift.sv
`timescale 1ns/1ps
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int PER_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  line_fmt_t         fmt,
  input  logic [DATA_W-1:0] data,
  input  logic [PER_W-1:0]  period_in,
  input  logic              tick,
  output logic              txd,
  output logic              busy,
  output logic              done,
  output logic [PER_W-1:0]  period_q
);
  logic [CNT_W-1:0]  nb, after_start, left;
  logic [DATA_W-1:0] d_m;
  logic              par;
  logic [BODY_W-1:0] body, sh;

  assign nb = CNT_W'(5) + CNT_W'(fmt.len_code);
  assign after_start = nb + CNT_W'(fmt.par_en) + CNT_W'(1) + CNT_W'(fmt.two_stop);

  always_comb begin
    body = '1;
    d_m  = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (CNT_W'(i) < nb) begin
        d_m[i]  = data[i];
        body[i] = data[i];
      end
    end
    par = fmt.par_even ? ^d_m : ~^d_m;
    for (int i = 0; i <= DATA_W; i++) begin
      if (fmt.par_en && CNT_W'(i) == nb) body[i] = par;
    end
  end

  assign done = busy && tick && (left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      txd      <= 1'b1;
      busy     <= 1'b0;
      sh       <= '1;
      left     <= '0;
      period_q <= '0;
    end else if (!busy && start) begin
      busy     <= 1'b1;
      txd      <= 1'b0;
      sh       <= body;
      left     <= after_start;
      period_q <= period_in;
    end else if (busy && tick) begin
      if (left == '0) begin
        busy <= 1'b0;
        txd  <= 1'b1;
      end else begin
        txd  <= sh[0];
        sh   <= {1'b1, sh[BODY_W-1:1]};
        left <= left - CNT_W'(1);
      end
    end
  end

  p_idle_high_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  p_start_low_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);
  p_bit_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(txd));
  p_period_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(period_q));
endmodule

// File: rtl/uart_tx_framer.sv
`timescale 1ns/1ps
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int SCALED_W = 16,
  parameter int FRAC_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DIV_W-1:0]  cfg_wdata,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              txd,
  output logic              buf_empty,
  output logic              xmit_empty
);
  localparam int PER_W = SCALED_W + 1;

  line_fmt_t         fmt;
  logic [PER_W-1:0]  period, period_q;
  logic              div_nz, tick, busy, done, start, accept;
  logic              hold_full, buf_empty_q, xmit_empty_q;
  logic [DATA_W-1:0] hold_data;

  uart_tx_cfg #(.DIV_W(DIV_W), .SCALED_W(SCALED_W), .FRAC_W(FRAC_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .fmt(fmt), .period(period), .div_nz(div_nz)
  );

  uart_tx_baud #(.PER_W(PER_W)) u_baud (
    .clk(clk), .rst(rst), .run(busy), .period(period_q), .tick(tick)
  );

  uart_tx_shift #(.PER_W(PER_W)) u_shift (
    .clk(clk), .rst(rst), .start(start), .fmt(fmt), .data(hold_data),
    .period_in(period), .tick(tick), .txd(txd), .busy(busy), .done(done),
    .period_q(period_q)
  );

  assign accept = tx_valid && buf_empty_q;
  assign start  = hold_full && !busy && div_nz;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full    <= 1'b0;
      hold_data    <= '0;
      buf_empty_q  <= 1'b1;
      xmit_empty_q <= 1'b1;
    end else if (accept) begin
      hold_full    <= 1'b1;
      hold_data    <= tx_data;
      buf_empty_q  <= 1'b0;
      xmit_empty_q <= 1'b0;
    end else if (done) begin
      hold_full    <= 1'b0;
      buf_empty_q  <= 1'b1;
      xmit_empty_q <= 1'b1;
    end
  end

  assign tx_ready   = buf_empty_q;
  assign buf_empty  = buf_empty_q;
  assign xmit_empty = xmit_empty_q;

  p_accept_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> (!buf_empty && !xmit_empty));
  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !tx_ready);
  p_zero_div_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!div_nz && !busy) |=> !busy);
endmodule

// File: tb/uart_tx_framer_bench.sv
`timescale 1ns/1ps
module uart_tx_framer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_ready, txd, buf_empty, xmit_empty;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  uart_tx_framer u_uart_tx_framer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .txd(txd),
    .buf_empty(buf_empty), .xmit_empty(xmit_empty)
  );

  // {format, divisor, fraction, byte}
  localparam logic [39:0] VEC [8] = '{
    {8'h03, 16'h0001, 8'h00, 8'hA5},
    {8'h00, 16'h0001, 8'h03, 8'h3C},
    {8'h06, 16'h0002, 8'h00, 8'h55},
    {8'h2B, 16'h0001, 8'h07, 8'h07},
    {8'h23, 16'h0001, 8'h01, 8'h07},
    {8'h2E, 16'h0001, 8'h00, 8'h80},
    {8'h03, 16'h1000, 8'h02, 8'hF0},
    {8'h01, 16'h0001, 8'h0F, 8'h5A}
  };

  function automatic string req_of(input int i);
    case (i)
      0: return "R2 R8 8N1";
      1: return "R2 5-bit";
      2: return "R3 two-stop";
      3: return "R4 even";
      4: return "R4 odd";
      5: return "R3 R4 7-bit even";
      6: return "R5 wrap";
      default: return "R5 R10 frac";
    endcase
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // Called at the negedge right after the accept (or enabling) edge.
  task automatic capture(input logic [7:0] lcr, input logic [15:0] dv, input logic [7:0] fr,
                         input logic [7:0] d, input string req, input bit inject);
    int p, nb, n;
    logic [15:0] bits;
    logic [7:0]  dm;
    p  = ((int'(dv) * 16) & 32'hFFFF) + int'(fr & 8'h07) + 16;
    nb = int'(lcr[1:0]) + 5;
    dm = '0;
    bits = 16'hFFFF;
    bits[0] = 1'b0;
    for (int i = 0; i < nb; i++) begin
      bits[1+i] = d[i];
      dm[i] = d[i];
    end
    n = 1 + nb;
    if (lcr[5]) begin
      bits[n] = lcr[3] ? ^dm : ~^dm;
      n++;
    end
    n = n + 1 + int'(lcr[2]);
    @(negedge clk);
    for (int c = 0; c < n * p; c++) begin
      if (c % p == p / 2)
        chk($sformatf("%s bit%0d", req, c / p), {31'b0, txd}, {31'b0, bits[c/p]});
      if (c == p / 2) chk("R7 tx_ready low while sending", {31'b0, tx_ready}, 32'd0);
      if (c == n * p - 1) begin
        chk("R7 buf_empty held until frame end", {31'b0, buf_empty}, 32'd0);
        chk("R7 xmit_empty held until frame end", {31'b0, xmit_empty}, 32'd0);
      end
      if (inject) begin
        if (c == 1) begin cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 16'd2; end
        if (c == 2) begin cfg_sel = 2'd0; cfg_wdata = 16'd0; end
        if (c == 3) cfg_we = 1'b0;
      end
      @(negedge clk);
    end
    chk({req, " R7 buf_empty after frame"}, {31'b0, buf_empty}, 32'd1);
    chk({req, " R7 xmit_empty after frame"}, {31'b0, xmit_empty}, 32'd1);
    chk({req, " R8 idle high"}, {31'b0, txd}, 32'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int lows;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd", {31'b0, txd}, 32'd1);
    chk("R1 buf_empty", {31'b0, buf_empty}, 32'd1);
    chk("R1 xmit_empty", {31'b0, xmit_empty}, 32'd1);
    chk("R1 tx_ready", {31'b0, tx_ready}, 32'd1);

    // R6 divisor still 0 from reset (R1): byte must wait
    cfg_write(2'd0, 16'h0003);
    send_byte(8'h96);
    lows = 0;
    repeat (100) begin
      @(negedge clk);
      if (!txd) lows++;
    end
    chk("R6 line stays high with zero divisor", lows, 0);
    chk("R6 buf_empty stays 0", {31'b0, buf_empty}, 32'd0);
    chk("R6 xmit_empty stays 0", {31'b0, xmit_empty}, 32'd0);
    chk("R6 tx_ready stays 0", {31'b0, tx_ready}, 32'd0);
    cfg_write(2'd1, 16'h0001);
    capture(8'h03, 16'h0001, 8'h00, 8'h96, "R6 release", 1'b0);

    // Table walk
    for (int i = 0; i < 8; i++) begin
      cfg_write(2'd0, {8'h00, VEC[i][39:32]});
      cfg_write(2'd1, VEC[i][31:16]);
      cfg_write(2'd2, {8'h00, VEC[i][15:8]});
      cfg_write(2'd3, 16'hFFFF); // R10: must be ignored
      send_byte(VEC[i][7:0]);
      capture(VEC[i][39:32], VEC[i][31:16], VEC[i][15:8], VEC[i][7:0], req_of(i), 1'b0);
    end

    // R9: rewrites during a character apply to the next one
    cfg_write(2'd0, 16'h0003);
    cfg_write(2'd1, 16'h0001);
    cfg_write(2'd2, 16'h0000);
    send_byte(8'hC3);
    capture(8'h03, 16'h0001, 8'h00, 8'hC3, "R9 old cfg kept", 1'b1);
    send_byte(8'h1F);
    capture(8'h00, 16'h0002, 8'h00, 8'h1F, "R9 new cfg used", 1'b0);

    summary();
    $finish;
  end
endmodule